// File: doc/BRIEF.md
# Pseudo-SRAM Write Sequencer

This block sits between a synchronous host and an asynchronous low-power pseudo-SRAM. It takes one write request at a time over a valid/ready handshake. Each request carries an address, a 16-bit data word, two byte enables and a framing mode. The block then drives the memory's chip select, write enable, upper and lower byte selects and data bus. All setup, pulse, hold and recovery intervals are counted in system clock cycles and set by parameters. The sleep pin is kept high at all times, because sleep entry is outside this block's function.

The framing mode picks which strobe opens and closes the write pulse: write enable, chip select or the byte selects. The other strobes go low when the address is presented and stay low until recovery ends. A burst guard watches for long runs of back-to-back transactions. Once a run reaches a time limit, it forces an idle gap of at least one minimum cycle time before the next request is taken.

Top module: `psram_wr_seq`

## Requirements
- R1: After reset, chip select, write enable and both byte selects are high, the data bus is high impedance, the sleep pin is high and ready is high.
- R2: The framing mode is sampled at acceptance. 0 frames with write enable, 1 with chip select, 2 with the byte selects, and 3 behaves as 0. The framing strobe is low only during the active window. The non-framing strobes are low from the first setup cycle to the last recovery cycle. All strobes are high while idle.
- R3: Enable bit 1 drives the upper byte select and enable bit 0 drives the lower byte select. An enable that is clear keeps its select high for the whole transaction, so a request with both bits clear writes nothing.
- R4: The memory address takes the request address at acceptance and does not change until the next acceptance. The write (chip select, write enable and at least one byte select all low) begins exactly S = max(tAS,1) cycles after the address changes.
- R5: The write overlap lasts exactly L = max(tWP, tCW, tDW, 1) cycles.
- R6: The data bus carries the request data during the whole active window and the first tDH recovery cycles. It is high impedance otherwise.
- R7: The sleep pin is high in every cycle.
- R8: Ready is low for S+L+R cycles after acceptance, where R = max(tWR, tDH, 1, tWC-1-S-L), and is high in the cycle after that. Back-to-back address changes are therefore S+L+R+1 cycles apart, which is never less than tWC.
- R9: Busy cycles and accepting cycles add to a streak count. An idle cycle without acceptance clears it. When the streak reaches BURST_US*CLK_MHZ cycles, ready is held low for max(tWC,1) idle cycles. After that the streak clears and requests are taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host write request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Write address |
| req_data | input | 2*BYTE_W | Write data word |
| req_be | input | 2 | Byte enables (bit 1 upper, bit 0 lower) |
| req_frame | input | 2 | Framing mode (0 write enable, 1 chip select, 2 byte selects, 3 as 0) |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | inout | 2*BYTE_W | Memory data bus, driven only inside the data window |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_sleep_n | output | 1 | Sleep pin, held high |

## Verification
The assertions assume that the host holds the request fields steady while valid is high and not yet accepted. They also assume that nothing else drives the data bus, since reads are outside this block's function. The bench changes its inputs only on falling clock edges and leaves every request asserted until ready is seen. It drops valid right after acceptance and inserts an idle cycle between sweep writes, so the burst guard stays quiet until the dedicated back-to-back run.

// File: rtl/psram_wr_pkg.sv
`timescale 1ns/1ps
package psram_wr_pkg;

    typedef enum logic [1:0] {
        FRAME_WE   = 2'd0,
        FRAME_CS   = 2'd1,
        FRAME_BYTE = 2'd2
    } frame_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_ACTIVE  = 2'd2,
        PH_RECOVER = 2'd3
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic dq_oe;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic frame_e to_frame(input logic [1:0] code);
        case (code)
            2'd1:    return FRAME_CS;
            2'd2:    return FRAME_BYTE;
            default: return FRAME_WE;
        endcase
    endfunction

    function automatic pins_t strobe_map(input phase_e ph, input frame_e fm,
                                         input logic [1:0] be, input logic drive);
        pins_t p;
        logic  busy;
        logic  act;
        logic  sel;
        busy    = (ph != PH_IDLE);
        act     = (ph == PH_ACTIVE);
        p.cs_n  = !busy || ((fm == FRAME_CS) && !act);
        p.we_n  = !busy || ((fm == FRAME_WE) && !act);
        sel     = busy && ((fm == FRAME_BYTE) ? act : 1'b1);
        p.ub_n  = !(sel && be[1]);
        p.lb_n  = !(sel && be[0]);
        p.dq_oe = drive;
        return p;
    endfunction

endpackage

// File: rtl/psram_wr_fsm.sv
`timescale 1ns/1ps
module psram_wr_fsm
    import psram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned T_AS   = 1,
    parameter int unsigned T_WP   = 5,
    parameter int unsigned T_CW   = 6,
    parameter int unsigned T_DW   = 3,
    parameter int unsigned T_DH   = 1,
    parameter int unsigned T_WR   = 1,
    parameter int unsigned T_WC   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    input  logic [1:0]        req_frame,
    input  logic              block,
    output logic              req_ready,
    output logic              idle,
    output logic              accept,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] wr_data,
    output pins_t             pins
);
    localparam int unsigned LEN_SETUP = max2(T_AS, 1);
    localparam int unsigned LEN_ACT   = max2(max2(T_WP, T_CW), max2(T_DW, 1));
    localparam int unsigned REC_MIN   = max2(max2(T_WR, T_DH), 1);
    localparam int unsigned FILL      = (T_WC > 1 + LEN_SETUP + LEN_ACT) ?
                                        (T_WC - 1 - LEN_SETUP - LEN_ACT) : 0;
    localparam int unsigned LEN_REC   = max2(REC_MIN, FILL);
    localparam int unsigned LEN_MAX   = max2(max2(LEN_SETUP, LEN_ACT), LEN_REC);
    localparam int unsigned TW        = $clog2(LEN_MAX + 1);
    localparam logic [TW-1:0] SET_LAST = TW'(LEN_SETUP - 1);
    localparam logic [TW-1:0] ACT_LAST = TW'(LEN_ACT - 1);
    localparam logic [TW-1:0] REC_LAST = TW'(LEN_REC - 1);
    localparam logic [TW-1:0] DH_CNT   = TW'(T_DH);

    phase_e            ph_q, ph_d;
    logic [TW-1:0]     tick_q, tick_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [1:0]        be_q, be_d;
    frame_e            frame_q, frame_d;
    pins_t             pins_q, pins_d;
    logic              drive_d;

    assign idle      = (ph_q == PH_IDLE);
    assign req_ready = idle && !block;
    assign accept    = req_valid && req_ready;

    always_comb begin
        ph_d   = ph_q;
        tick_d = tick_q + 1'b1;
        case (ph_q)
            PH_IDLE: begin
                tick_d = '0;
                if (accept) ph_d = PH_SETUP;
            end
            PH_SETUP: begin
                if (tick_q == SET_LAST) begin
                    ph_d   = PH_ACTIVE;
                    tick_d = '0;
                end
            end
            PH_ACTIVE: begin
                if (tick_q == ACT_LAST) begin
                    ph_d   = PH_RECOVER;
                    tick_d = '0;
                end
            end
            default: begin
                if (tick_q == REC_LAST) begin
                    ph_d   = PH_IDLE;
                    tick_d = '0;
                end
            end
        endcase
        frame_d = accept ? to_frame(req_frame) : frame_q;
        be_d    = accept ? req_be : be_q;
        drive_d = (ph_d == PH_ACTIVE) || ((ph_d == PH_RECOVER) && (tick_d < DH_CNT));
        pins_d  = strobe_map(ph_d, frame_d, be_d, drive_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            tick_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            be_q    <= '0;
            frame_q <= FRAME_WE;
            pins_q  <= PINS_IDLE;
        end else begin
            ph_q    <= ph_d;
            tick_q  <= tick_d;
            be_q    <= be_d;
            frame_q <= frame_d;
            pins_q  <= pins_d;
            if (accept) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
        end
    end

    assign mem_addr = addr_q;
    assign wr_data  = data_q;
    assign pins     = pins_q;

    logic write_on;
    assign write_on = !pins_q.cs_n && !pins_q.we_n && (!pins_q.ub_n || !pins_q.lb_n);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE) |=> $stable(addr_q))
        else $error("address moved during a transaction");

    assert_setup_before_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(write_on) |-> $stable(addr_q))
        else $error("address changed as the write began");

    assert_data_in_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        write_on |-> pins_q.dq_oe)
        else $error("data bus released during write overlap");

    assert_data_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(write_on) |-> $past(pins_q.dq_oe))
        else $error("data not driven when the write ended");

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready)
        else $error("ready stayed high after acceptance");

endmodule

// File: rtl/psram_burst_guard.sv
`timescale 1ns/1ps
module psram_burst_guard #(
    parameter int unsigned LIMIT = 2000,
    parameter int unsigned GAP   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic accept,
    output logic hold
);
    localparam int unsigned LIM_E = (LIMIT > 0) ? LIMIT : 1;
    localparam int unsigned GAP_E = (GAP > 0) ? GAP : 1;
    localparam int unsigned CW    = $clog2(LIM_E + 1);
    localparam int unsigned GW    = $clog2(GAP_E + 1);
    localparam logic [CW-1:0] LIM_C    = CW'(LIM_E);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_E - 1);

    logic [CW-1:0] streak_q;
    logic [GW-1:0] gap_q;

    assign hold = (streak_q == LIM_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            streak_q <= '0;
            gap_q    <= '0;
        end else if (hold) begin
            if (idle) begin
                if (gap_q == GAP_LAST) begin
                    streak_q <= '0;
                    gap_q    <= '0;
                end else begin
                    gap_q <= gap_q + 1'b1;
                end
            end
        end else if (idle && !accept) begin
            streak_q <= '0;
        end else begin
            streak_q <= streak_q + 1'b1;
        end
    end

    assert_gap_ends_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> $past(idle))
        else $error("burst hold released outside an idle gap");

    assert_no_accept_in_hold_R9: assert property (@(posedge clk) disable iff (rst)
        hold |-> !accept)
        else $error("request accepted during burst hold");

endmodule

// File: rtl/psram_wr_seq.sv
`timescale 1ns/1ps
module psram_wr_seq
    import psram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned T_AS     = 1,
    parameter int unsigned T_WP     = 5,
    parameter int unsigned T_CW     = 6,
    parameter int unsigned T_DW     = 3,
    parameter int unsigned T_DH     = 1,
    parameter int unsigned T_WR     = 1,
    parameter int unsigned T_WC     = 8,
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned BURST_US = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2*BYTE_W-1:0]   req_data,
    input  logic [1:0]            req_be,
    input  logic [1:0]            req_frame,
    output logic [ADDR_W-1:0]     mem_addr,
    inout  wire  [2*BYTE_W-1:0]   mem_dq,
    output logic                  mem_cs_n,
    output logic                  mem_we_n,
    output logic                  mem_ub_n,
    output logic                  mem_lb_n,
    output logic                  mem_sleep_n
);
    localparam int unsigned DATA_W = 2 * BYTE_W;
    localparam int unsigned LIMIT  = BURST_US * CLK_MHZ;
    localparam int unsigned GAP    = max2(T_WC, 1);

    logic              guard_hold;
    logic              idle;
    logic              accept;
    logic [DATA_W-1:0] wr_data;
    pins_t             pins;

    psram_wr_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .T_AS(T_AS), .T_WP(T_WP), .T_CW(T_CW), .T_DW(T_DW),
        .T_DH(T_DH), .T_WR(T_WR), .T_WC(T_WC)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_be(req_be), .req_frame(req_frame), .block(guard_hold),
        .req_ready(req_ready), .idle(idle), .accept(accept),
        .mem_addr(mem_addr), .wr_data(wr_data), .pins(pins)
    );

    psram_burst_guard #(.LIMIT(LIMIT), .GAP(GAP)) u_guard (
        .clk(clk), .rst(rst), .idle(idle), .accept(accept), .hold(guard_hold)
    );

    assign mem_dq      = pins.dq_oe ? wr_data : {DATA_W{1'bz}};
    assign mem_cs_n    = pins.cs_n;
    assign mem_we_n    = pins.we_n;
    assign mem_ub_n    = pins.ub_n;
    assign mem_lb_n    = pins.lb_n;
    assign mem_sleep_n = 1'b1;

    assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        guard_hold |-> !req_ready)
        else $error("ready high while burst guard holds");

endmodule

// File: tb/psram_wr_seq_test.sv
`timescale 1ns/1ps
module psram_wr_seq_test;
    localparam int TAS = 2, TWP = 3, TCW = 2, TDW = 2, TDH = 2, TWR = 1, TWC = 9;
    localparam int MHZ = 1, BUS = 20;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int S     = mx(TAS, 1);
    localparam int L     = mx(mx(TWP, TCW), mx(TDW, 1));
    localparam int R     = mx(mx(mx(TWR, TDH), 1), TWC - 1 - S - L);
    localparam int TOT   = S + L + R;
    localparam int P     = TOT + 1;
    localparam int LIMIT = BUS * MHZ;
    localparam int GAPC  = mx(TWC, 1);
    localparam int NFIT  = (LIMIT + P - 1) / P;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic        ready;
    logic [15:0] addr = '0;
    logic [15:0] data = '0;
    logic [1:0]  be = '0;
    logic [1:0]  frame = '0;
    logic [15:0] maddr;
    wire  [15:0] dq;
    logic        cs_n, we_n, ub_n, lb_n, sleep_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psram_wr_seq #(
        .ADDR_W(16), .BYTE_W(8), .T_AS(TAS), .T_WP(TWP), .T_CW(TCW), .T_DW(TDW),
        .T_DH(TDH), .T_WR(TWR), .T_WC(TWC), .CLK_MHZ(MHZ), .BURST_US(BUS)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(valid), .req_ready(ready),
        .req_addr(addr), .req_data(data), .req_be(be), .req_frame(frame),
        .mem_addr(maddr), .mem_dq(dq), .mem_cs_n(cs_n), .mem_we_n(we_n),
        .mem_ub_n(ub_n), .mem_lb_n(lb_n), .mem_sleep_n(sleep_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_pins(input string tag);
        chk({tag, " cs"}, {31'd0, cs_n}, 32'd1);
        chk({tag, " we"}, {31'd0, we_n}, 32'd1);
        chk({tag, " ub"}, {31'd0, ub_n}, 32'd1);
        chk({tag, " lb"}, {31'd0, lb_n}, 32'd1);
        chk({tag, " dq"}, {16'd0, dq}, {16'd0, 16'hzzzz});
        chk("R7 sleep", {31'd0, sleep_n}, 32'd1);
    endtask

    task automatic write_one(input int mode, input logic [1:0] ben,
                             input logic [15:0] a, input logic [15:0] d);
        int  ov;
        int  first_ov;
        int  k;
        int  ph;
        bit  act;
        bit  e_cs, e_we, e_ub, e_lb, e_oe;
        ov = 0;
        first_ov = 0;
        k = (mode == 1) ? 1 : (mode == 2) ? 2 : 0;
        @(negedge clk);
        addr = a; data = d; be = ben; frame = 2'(mode); valid = 1'b1;
        while (!ready) @(negedge clk);
        for (int j = 1; j <= TOT; j++) begin
            @(negedge clk);
            if (j == 1) valid = 1'b0;
            ph   = (j <= S) ? 1 : (j <= S + L) ? 2 : 3;
            act  = (ph == 2);
            e_cs = (k == 1) ? !act : 1'b0;
            e_we = (k == 0) ? !act : 1'b0;
            e_ub = !ben[1] ? 1'b1 : ((k == 2) ? !act : 1'b0);
            e_lb = !ben[0] ? 1'b1 : ((k == 2) ? !act : 1'b0);
            e_oe = act || ((ph == 3) && (j - S - L <= TDH));
            chk("R2 cs", {31'd0, cs_n}, {31'd0, e_cs});
            chk("R2 we", {31'd0, we_n}, {31'd0, e_we});
            chk("R3 ub", {31'd0, ub_n}, {31'd0, e_ub});
            chk("R3 lb", {31'd0, lb_n}, {31'd0, e_lb});
            chk("R6 dq", {16'd0, dq}, {16'd0, e_oe ? d : 16'hzzzz});
            chk("R4 addr", {16'd0, maddr}, {16'd0, a});
            chk("R7 sleep", {31'd0, sleep_n}, 32'd1);
            chk("R8 busy ready", {31'd0, ready}, 32'd0);
            if (!cs_n && !we_n && (!ub_n || !lb_n)) begin
                if (ov == 0) first_ov = j;
                ov++;
            end
        end
        chk("R5 overlap length", ov, (ben != 2'b00) ? L : 0);
        if (ben != 2'b00) chk("R4 setup cycles", first_ov, S + 1);
        @(negedge clk);
        chk("R8 ready back", {31'd0, ready}, 32'd1);
        idle_pins("R2 idle");
        chk("R4 addr kept", {16'd0, maddr}, {16'd0, a});
    endtask

    initial begin
        int acc [0:6];
        int n;
        int guard_i;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        idle_pins("R1 reset");
        chk("R1 ready", {31'd0, ready}, 32'd1);

        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 4; b++) begin
                for (int p = 0; p < 2; p++) begin
                    write_one(m, 2'(b),
                              16'(16'h1357 * (m * 8 + b * 2 + p + 1)),
                              16'(p ? (16'hC3A5 ^ (b << 8) ^ m) : (16'h5A0F + m * 16 + b)));
                end
            end
        end

        @(negedge clk);
        n = 0;
        guard_i = 0;
        valid = 1'b1;
        addr = 16'h0100;
        while (n < 7 && guard_i < 400) begin
            if (ready) begin
                acc[n] = cyc;
                n++;
                @(posedge clk);
                @(negedge clk);
                addr = 16'(16'h0100 + n);
            end else begin
                @(negedge clk);
            end
            guard_i++;
        end
        valid = 1'b0;
        chk("R9 accepts seen", n, 7);
        for (int i = 1; i < 7; i++) begin
            if (i < n)
                chk((i % NFIT == 0) ? "R9 guarded gap" : "R8 spacing",
                    acc[i] - acc[i-1], (i % NFIT == 0) ? (P + GAPC) : P);
        end
        repeat (TOT + 2) @(negedge clk);
        idle_pins("R2 after burst");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule